// File: doc/BRIEF.md
# Self-Timed Clear-Then-Program Write Sequencer

This block carries out the nonvolatile update operations of a serial memory once its interface front end has decoded an instruction and seen the select line fall. The front end hands it one launch pulse with four pieces of information: an operation code (single write, single erase, fill-all or clear-all), an address, a data word and the organization flag (word or byte). From then on the block needs no serial clock. It times the whole operation on the system clock, keeps a busy flag high while it runs, and updates an internal register array. The front end reads that array through a separate combinational read port.

Every operation starts with a clear phase that drives its target bits to logic one. Erase operations stop after that phase. Write operations then run a program phase that stores the data, so a location never needs a separate erase before it is written. A small write-enable latch gates every launch. That latch can be set or cleared only while the sequencer is idle.

The controller has four states. IDLE waits for an accepted launch (transition IDLE to CLEAR). CLEAR counts `CLEAR_CYCLES` clock cycles and clears the target on its last cycle. From there it goes to PROGRAM for write and fill-all, or straight to DONE for erase and clear-all. PROGRAM counts `PROG_CYCLES` cycles and stores the data pattern on its last cycle (transition PROGRAM to DONE). DONE lasts one cycle and always returns to IDLE, which drops the busy flag.

Top module: `nvm_write_sequencer`

## Requirements
- R1: After reset the busy flag is low, writes are disabled, and every array word reads 16'hFFFF.
- R2: A pulse on `wen_req` while idle loads `wen_val` into `wr_enabled`, which is visible at the next sample. A request made while busy leaves `wr_enabled` unchanged.
- R3: A launch made while writes are disabled is ignored: busy stays low and the array is unchanged.
- R4: An accepted launch raises busy at the next sample. Busy stays high for exactly CLEAR_CYCLES+PROG_CYCLES+1 cycles for write and fill-all (op 2'b00, 2'b10), and for CLEAR_CYCLES+1 cycles for erase and clear-all (op 2'b01, 2'b11).
- R5: Launches and enable requests that arrive while busy have no effect on the array or on the enable state.
- R6: A single write (op 2'b00) shows the target bits as all ones from the cycle after the clear phase ends, then ends with the data stored. All other bits of the array are untouched.
- R7: A single erase (op 2'b01) leaves its target bits at all ones.
- R8: Clear-all (op 2'b11) sets every bit of the array to one.
- R9: Fill-all (op 2'b10) in word organization stores the data word in every location.
- R10: With `cmd_byte`/`rd_byte` set, the address is a byte address. Bit 0 selects the lane (1 selects bits 15:8, 0 selects bits 7:0) and the upper bits select the word. A byte write or erase changes only that lane. A byte read returns the lane zero-extended to 16 bits.
- R11: Fill-all in byte organization stores the low data byte in both lanes of every word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that times every phase |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle launch pulse from the interface front end |
| cmd_op | input | 2 | 00 write, 01 erase, 10 fill-all, 11 clear-all |
| cmd_addr | input | 7 | Word address, or byte address when `cmd_byte` is set |
| cmd_data | input | 16 | Data word; only bits 7:0 are used in byte organization |
| cmd_byte | input | 1 | Byte organization for the launched command |
| wen_req | input | 1 | Pulse that requests a change of the write-enable state |
| wen_val | input | 1 | New write-enable value carried by `wen_req` |
| wr_enabled | output | 1 | Current write-enable state |
| busy | output | 1 | Registered busy flag |
| rd_addr | input | 7 | Read address, interpreted as for `cmd_addr` |
| rd_byte | input | 1 | Byte organization for the read port |
| rd_data | output | 16 | Combinational read data |

## Verification
The assertions check on every cycle that busy follows an accepted launch and never follows a locked-out one. They also check that busy holds until DONE and then falls, that the array is updated only while busy, that the enable latch is frozen during busy, and that the phase counter never passes its limit. Other behaviours can only be shown by the bench's scenarios, because they depend on the data held across the array: the value seen at the target between the two phases, the final stored contents, lane isolation in byte organization, and the full-array effect of the fill and clear operations.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_ERASE = 2'b01,
        OP_FILL  = 2'b10,
        OP_CLEAR = 2'b11
    } nvm_op_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CLEAR = 2'd1,
        S_PROG  = 2'd2,
        S_DONE  = 2'd3
    } seq_state_e;

    function automatic logic op_is_erase(nvm_op_e op);
        return (op == OP_ERASE) || (op == OP_CLEAR);
    endfunction

    function automatic logic op_is_global(nvm_op_e op);
        return (op == OP_FILL) || (op == OP_CLEAR);
    endfunction

endpackage

// File: rtl/nvm_phase_timer.sv
module nvm_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= '0;
        else if (en)
            cnt_q <= cnt_q + 1'b1;
    end

    assign last = en && (cnt_q == limit - 1'b1);

    // R4: a running phase never counts past its programmed length
    p_cnt_in_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt_q < limit));

endmodule

// File: rtl/nvm_wen_ctrl.sv
module nvm_wen_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic val,
    input  logic busy,
    output logic enabled
);
    logic en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (req && !busy)
            en_q <= val;
    end

    assign enabled = en_q;

    // R2: the enable state is frozen while an operation runs
    p_wen_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(en_q));

endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 7,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int BYTE_W = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic              upd_all,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [WORD_W-1:0] upd_mask,
    input  logic [WORD_W-1:0] upd_val,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_byte,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    generate
        for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem_q[gi] <= '1;
                else if (upd_en && (upd_all || (upd_idx == IDX_W'(gi))))
                    mem_q[gi] <= (mem_q[gi] & ~upd_mask) | (upd_val & upd_mask);
            end
        end
    endgenerate

    logic [IDX_W-1:0]  rd_idx;
    logic [WORD_W-1:0] rd_word;

    always_comb begin
        rd_idx  = rd_byte ? rd_addr[IDX_W:1] : rd_addr[IDX_W-1:0];
        rd_word = mem_q[rd_idx];
        if (rd_byte)
            rd_data = {{BYTE_W{1'b0}},
                       (rd_addr[0] ? rd_word[WORD_W-1:BYTE_W] : rd_word[BYTE_W-1:0])};
        else
            rd_data = rd_word;
    end

endmodule

// File: rtl/nvm_write_sequencer.sv
module nvm_write_sequencer
    import nvm_seq_pkg::*;
#(
    parameter int WORD_W       = 16,
    parameter int DEPTH        = 64,
    parameter int CLEAR_CYCLES = 8,
    parameter int PROG_CYCLES  = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    input  logic [1:0]                  cmd_op,
    input  logic [$clog2(DEPTH):0]      cmd_addr,
    input  logic [WORD_W-1:0]           cmd_data,
    input  logic                        cmd_byte,
    input  logic                        wen_req,
    input  logic                        wen_val,
    output logic                        wr_enabled,
    output logic                        busy,
    input  logic [$clog2(DEPTH):0]      rd_addr,
    input  logic                        rd_byte,
    output logic [WORD_W-1:0]           rd_data
);
    localparam int IDX_W   = $clog2(DEPTH);
    localparam int ADDR_W  = IDX_W + 1;
    localparam int BYTE_W  = WORD_W / 2;
    localparam int MAX_PH  = (CLEAR_CYCLES > PROG_CYCLES) ? CLEAR_CYCLES : PROG_CYCLES;
    localparam int CNT_W   = $clog2(MAX_PH + 1);

    seq_state_e        state_q, state_nx;
    logic              busy_q;
    nvm_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;
    logic              byte_q;

    logic              accept;
    logic              tmr_start, tmr_en, tmr_last;
    logic [CNT_W-1:0]  tmr_limit;
    logic              upd_en;
    logic [WORD_W-1:0] upd_val, upd_mask, prog_pat;
    logic [IDX_W-1:0]  upd_idx;
    logic              upd_all;

    assign accept = cmd_valid && wr_enabled && (state_q == S_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            busy_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            busy_q  <= (state_nx != S_IDLE);
        end
    end

    // command capture at launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_WRITE;
            addr_q <= '0;
            data_q <= '0;
            byte_q <= 1'b0;
        end else if (accept) begin
            op_q   <= nvm_op_e'(cmd_op);
            addr_q <= cmd_addr;
            data_q <= cmd_data;
            byte_q <= cmd_byte;
        end
    end

    // target decode from the captured command
    always_comb begin
        upd_all = op_is_global(op_q);
        if (byte_q) begin
            upd_idx  = addr_q[IDX_W:1];
            prog_pat = {2{data_q[BYTE_W-1:0]}};
            if (upd_all)
                upd_mask = '1;
            else if (addr_q[0])
                upd_mask = {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}};
            else
                upd_mask = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
        end else begin
            upd_idx  = addr_q[IDX_W-1:0];
            prog_pat = data_q;
            upd_mask = '1;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx  = state_q;
        tmr_start = 1'b0;
        tmr_en    = 1'b0;
        tmr_limit = CNT_W'(CLEAR_CYCLES);
        upd_en    = 1'b0;
        upd_val   = '1;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    state_nx  = S_CLEAR;
                    tmr_start = 1'b1;
                end
            end
            S_CLEAR: begin
                tmr_en = 1'b1;
                if (tmr_last) begin
                    upd_en    = 1'b1;
                    upd_val   = '1;
                    tmr_start = 1'b1;
                    state_nx  = op_is_erase(op_q) ? S_DONE : S_PROG;
                end
            end
            S_PROG: begin
                tmr_en    = 1'b1;
                tmr_limit = CNT_W'(PROG_CYCLES);
                if (tmr_last) begin
                    upd_en   = 1'b1;
                    upd_val  = prog_pat;
                    state_nx = S_DONE;
                end
            end
            S_DONE: begin
                state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    assign busy = busy_q;

    nvm_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .en    (tmr_en),
        .limit (tmr_limit),
        .last  (tmr_last)
    );

    nvm_wen_ctrl u_wen (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (wen_req),
        .val     (wen_val),
        .busy    (busy_q),
        .enabled (wr_enabled)
    );

    nvm_cell_array #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .upd_all  (upd_all),
        .upd_idx  (upd_idx),
        .upd_mask (upd_mask),
        .upd_val  (upd_val),
        .rd_addr  (rd_addr),
        .rd_byte  (rd_byte),
        .rd_data  (rd_data)
    );

    // R4: an accepted launch raises busy on the next edge
    p_accept_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && wr_enabled && !busy) |=> busy);

    // R3: a launch while disabled leaves the block idle
    p_locked_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !wr_enabled && !busy) |=> !busy);

    // R5: busy cannot be cut short by new launches
    p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (state_q != S_DONE)) |=> busy);

    // R4: the single DONE cycle releases busy
    p_done_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE) |=> !busy);

    // R6: the array is only touched inside a running operation
    p_update_only_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> busy);

endmodule

// File: tb/nvm_write_sequencer_tb.sv
module nvm_write_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CC = 5;
    localparam int PC = 7;
    localparam int WDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [6:0]  cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic        cmd_byte = 1'b0;
    logic        wen_req = 1'b0;
    logic        wen_val = 1'b0;
    logic        wr_enabled, busy;
    logic [6:0]  rd_addr = '0;
    logic        rd_byte = 1'b0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [15:0] mm [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_write_sequencer #(.WORD_W(16), .DEPTH(64), .CLEAR_CYCLES(CC), .PROG_CYCLES(PC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_byte(cmd_byte),
        .wen_req(wen_req), .wen_val(wen_val), .wr_enabled(wr_enabled), .busy(busy),
        .rd_addr(rd_addr), .rd_byte(rd_byte), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] view(input logic [15:0] w, input logic [6:0] a, input bit bm);
        if (bm) return {8'h00, (a[0] ? w[15:8] : w[7:0])};
        return w;
    endfunction

    function automatic int widx(input logic [6:0] a, input bit bm);
        return bm ? int'(a[6:1]) : int'(a[5:0]);
    endfunction

    function automatic logic [15:0] lmask(input logic [6:0] a, input bit bm);
        if (!bm) return 16'hFFFF;
        return a[0] ? 16'hFF00 : 16'h00FF;
    endfunction

    task automatic model_apply(input logic [1:0] op, input logic [6:0] a,
                               input logic [15:0] d, input bit bm);
        logic [15:0] pat = bm ? {2{d[7:0]}} : d;
        logic [15:0] m = lmask(a, bm);
        int i = widx(a, bm);
        case (op)
            2'b00: mm[i] = (mm[i] & ~m) | (pat & m);
            2'b01: mm[i] = mm[i] | m;
            2'b10: for (int k = 0; k < 64; k++) mm[k] = pat;
            default: for (int k = 0; k < 64; k++) mm[k] = 16'hFFFF;
        endcase
    endtask

    task automatic set_wen(input bit v);
        @(negedge clk);
        wen_req = 1'b1; wen_val = v;
        @(negedge clk);
        wen_req = 1'b0;
        chk("R2 enable latch", {31'd0, wr_enabled}, {31'd0, v});
    endtask

    task automatic scan_all(input string req);
        for (int k = 0; k < 64; k++) begin
            rd_byte = 1'b0; rd_addr = 7'(k);
            #1;
            chk(req, {16'd0, rd_data}, {16'd0, mm[k]});
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [6:0] a, input logic [15:0] d,
                          input bit bm, input bit disturb, input bit expect_go);
        int n;
        int dur;
        logic [15:0] cleared;
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_data = d; cmd_byte = bm; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (!expect_go) begin
            chk("R3 locked launch keeps busy low", {31'd0, busy}, 32'd0);
            return;
        end
        chk("R4 busy after launch", {31'd0, busy}, 32'd1);
        cleared = mm[widx(a, bm)] | lmask(a, bm);
        rd_addr = a; rd_byte = bm;
        n = 1;
        while (busy === 1'b1 && n < 1000) begin
            if (disturb && n == 2) begin
                cmd_valid = 1'b1; cmd_op = 2'b10; cmd_data = 16'h0000; cmd_byte = 1'b0;
                wen_req = 1'b1; wen_val = 1'b0;
            end
            if (disturb && n == 3) begin
                cmd_valid = 1'b0; wen_req = 1'b0;
            end
            if (op == 2'b00 && n == CC + 1) begin
                #1;
                chk("R6 target cleared between phases", {16'd0, rd_data},
                    {16'd0, view(cleared, a, bm)});
            end
            @(negedge clk);
            n++;
        end
        cmd_valid = 1'b0; wen_req = 1'b0;
        dur = n - 1;
        chk("R4 busy length", dur, (op == 2'b00 || op == 2'b10) ? CC + PC + 1 : CC + 1);
        if (disturb) chk("R5 enable unchanged by request during busy", {31'd0, wr_enabled}, 32'd1);
        model_apply(op, a, d, bm);
        rd_addr = a; rd_byte = bm;
        #1;
        chk(op == 2'b01 ? "R7 erased target" : "R6 stored target", {16'd0, rd_data},
            {16'd0, view(mm[widx(a, bm)], a, bm)});
    endtask

    initial begin
        void'($urandom(32'h1357_2468));
        for (int k = 0; k < 64; k++) mm[k] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy low after reset", {31'd0, busy}, 32'd0);
        chk("R1 writes disabled after reset", {31'd0, wr_enabled}, 32'd0);
        scan_all("R1 array erased after reset");

        // R3: disabled launch ignored
        run_op(2'b00, 7'd5, 16'h1234, 1'b0, 1'b0, 1'b0);
        scan_all("R3 array unchanged after locked launch");

        set_wen(1'b1);
        // R6: word write with auto-clear
        run_op(2'b00, 7'd5, 16'hA5C3, 1'b0, 1'b0, 1'b1);
        run_op(2'b00, 7'd5, 16'h0F0F, 1'b0, 1'b0, 1'b1);
        // R7: erase
        run_op(2'b01, 7'd5, 16'h0000, 1'b0, 1'b0, 1'b1);
        // R10: byte lanes
        run_op(2'b00, 7'd21, 16'h003C, 1'b1, 1'b0, 1'b1);
        run_op(2'b00, 7'd20, 16'h0081, 1'b1, 1'b0, 1'b1);
        run_op(2'b01, 7'd21, 16'h0000, 1'b1, 1'b0, 1'b1);
        scan_all("R10 byte ops touch one lane only");
        // R5 and R2: disturbance during busy
        run_op(2'b00, 7'd63, 16'hBEEF, 1'b0, 1'b1, 1'b1);
        scan_all("R5 launch during busy ignored");
        // R9: fill-all word
        run_op(2'b10, 7'd0, 16'h6D92, 1'b0, 1'b0, 1'b1);
        scan_all("R9 fill-all word");
        // R11: fill-all byte
        run_op(2'b10, 7'd77, 16'hFF47, 1'b1, 1'b0, 1'b1);
        scan_all("R11 fill-all byte");
        // R8: clear-all
        run_op(2'b11, 7'd9, 16'h0000, 1'b0, 1'b0, 1'b1);
        scan_all("R8 clear-all");

        // constrained random mix
        for (int t = 0; t < 40; t++) begin
            int r = int'($urandom_range(0, 9));
            logic [1:0] op = (r < 5) ? 2'b00 : (r < 8) ? 2'b01 : (r < 9) ? 2'b10 : 2'b11;
            bit bm = bit'($urandom_range(0, 1));
            logic [6:0] a = bm ? 7'($urandom_range(0, 127)) : 7'($urandom_range(0, 63));
            run_op(op, a, 16'($urandom()), bm, bit'($urandom_range(0, 3) == 0), 1'b1);
        end
        scan_all("R6 array after random sequence");
        for (int t = 0; t < 32; t++) begin
            logic [6:0] a = 7'($urandom_range(0, 127));
            rd_byte = 1'b1; rd_addr = a;
            #1;
            chk("R10 byte read view", {16'd0, rd_data}, {16'd0, view(mm[a[6:1]], a, 1'b1)});
        end

        // R2: disable while idle, then launch is refused
        set_wen(1'b0);
        run_op(2'b11, 7'd0, 16'h0000, 1'b0, 1'b0, 1'b0);
        scan_all("R3 array unchanged after disable");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule